// File: doc/BRIEF.md
# Protection violation capture and interrupt

This block sits behind a memory permission checker. When the checker refuses an access it pulses a violation strobe and presents the offending address with three qualifiers: direction (read or write), kind (instruction fetch or data access), and whether the access was atomic. The block keeps the first such event in a status word and raises a pending flag. The flag drives an interrupt line when interrupts are enabled.

Software reaches the block through a small register port. Writes take one clock edge and reads are combinational. Three registers are mapped. A control register holds the enable bit, the read-only pending bit and a self-clearing clear bit. A status register holds the captured fault. A lock register holds a sticky bit that freezes the enable setting until the next reset.

The block has two status layouts, chosen by the parameter `DATA_SIDE`. Both record only address bits 21 down to 2. The address bits above that range are constant within one window, so they are not stored.

Top module: `pviol_capture`

## Requirements
- R1: After reset, the control, status and lock registers all read 0 and `irq` is low.
- R2: With `DATA_SIDE`=0, the status word holds faulting address bits [21:2] in bits [21:2]. Bit 1 holds the kind (1 = data, 0 = fetch), bit 0 holds the direction (1 = write, 0 = read), and the other bits read 0.
- R3: With `DATA_SIDE`=1, the status word holds faulting address bits [21:2] in bits [25:6]. Bit 5 holds the atomic flag (1 = atomic), bit 4 holds the direction (1 = write), and the other bits read 0.
- R4: A violation strobe sets pending (control bit 1) on the following edge whatever the enable bit (control bit 0) is. `irq` is high exactly when pending and enable are both 1.
- R5: While pending is set, further violations leave the status word unchanged.
- R6: Writing control with bit 2 = 1 (register select 0) clears pending, so the next violation is captured.
- R7: The clear bit reads 1 in the cycle after the write that set it and reads 0 one cycle later.
- R8: When a violation and a clear arrive in the same cycle, the new violation is captured and pending stays 1.
- R9: Writing 1 to bit 0 of the lock register (select 2) sets lock. Writing 0 does not release it; only reset does.
- R10: While lock is 1, writes to control leave the enable bit unchanged.
- R11: Writing bit 1 of control has no effect on pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| viol_valid | input | 1 | Denied-access strobe |
| viol_addr | input | ADDR_W | Faulting address |
| viol_write | input | 1 | 1 = write access |
| viol_data | input | 1 | 1 = data access, 0 = instruction fetch |
| viol_atomic | input | 1 | 1 = atomic access |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 lock |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds two instances side by side from the same stimulus: one with `DATA_SIDE`=0 and one with `DATA_SIDE`=1, both at the default 32-bit address width. Every captured fault is therefore compared against both status layouts at once. The address vectors include all-ones and all-zeros addresses and addresses with the low two bits set. These show that no bit outside [21:2] leaks into either layout, and that the flags land in their own positions.

// File: rtl/pvc_pkg.sv
package pvc_pkg;
  localparam int REG_W  = 32;
  localparam int SEL_W  = 2;
  localparam int MID_LO = 2;
  localparam int MID_HI = 21;
  localparam int MID_W  = MID_HI - MID_LO + 1;

  localparam logic [SEL_W-1:0] SEL_CTRL   = 2'd0;
  localparam logic [SEL_W-1:0] SEL_STATUS = 2'd1;
  localparam logic [SEL_W-1:0] SEL_LOCK   = 2'd2;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_PND_BIT = 1;
  localparam int CTRL_CLR_BIT = 2;

  // Instruction-side layout: address middle bits in place, kind at 1, direction at 0.
  function automatic logic [REG_W-1:0] pack_instr(input logic [MID_W-1:0] mid,
                                                  input logic is_data,
                                                  input logic is_wr);
    logic [REG_W-1:0] w;
    w = '0;
    w[MID_HI:MID_LO] = mid;
    w[1] = is_data;
    w[0] = is_wr;
    return w;
  endfunction

  // Data-side layout: address middle bits shifted up by four, atomic at 5, direction at 4.
  function automatic logic [REG_W-1:0] pack_data(input logic [MID_W-1:0] mid,
                                                 input logic is_atomic,
                                                 input logic is_wr);
    logic [REG_W-1:0] w;
    w = '0;
    w[MID_HI+4:MID_LO+4] = mid;
    w[5] = is_atomic;
    w[4] = is_wr;
    return w;
  endfunction
endpackage

// File: rtl/pvc_ctrl.sv
module pvc_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic viol,
  input  logic ctrl_wr,
  input  logic lock_wr,
  input  logic en_in,
  input  logic clr_in,
  input  logic lock_in,
  output logic en_q,
  output logic pend_q,
  output logic clr_q,
  output logic lock_q,
  output logic clear_evt,
  output logic capture_evt
);
  assign clear_evt   = ctrl_wr & clr_in;
  assign capture_evt = viol & (~pend_q | clear_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      clr_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      if (ctrl_wr && !lock_q) en_q <= en_in;
      if (viol)           pend_q <= 1'b1;
      else if (clear_evt) pend_q <= 1'b0;
      clr_q <= clear_evt;
      if (lock_wr && lock_in) lock_q <= 1'b1;
    end
  end

  // R4
  viol_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> pend_q);
  // R6
  clear_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_evt && !viol) |=> !pend_q);
  // R7
  clr_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && !clear_evt) |=> !clr_q);
  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  // R10
  en_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(en_q));
endmodule

// File: rtl/pvc_capture.sv
module pvc_capture
  import pvc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter bit DATA_SIDE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_wr,
  input  logic              is_data,
  input  logic              is_atomic,
  output logic [REG_W-1:0]  status_q
);
  logic [REG_W-1:0] packed_w;
  logic [MID_W-1:0] mid;
  logic             unused_addr_bits;

  assign mid = addr[MID_HI:MID_LO];
  assign unused_addr_bits = ^{addr[ADDR_W-1:MID_HI+1], addr[MID_LO-1:0]};

  generate
    if (DATA_SIDE) begin : g_dside
      logic unused_kind;
      assign unused_kind = is_data;
      assign packed_w = pack_data(mid, is_atomic, is_wr);
    end else begin : g_iside
      logic unused_atomic;
      assign unused_atomic = is_atomic;
      assign packed_w = pack_instr(mid, is_data, is_wr);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    status_q <= '0;
    else if (take) status_q <= packed_w;
  end
endmodule

// File: rtl/pviol_capture.sv
module pviol_capture
  import pvc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter bit DATA_SIDE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              viol_valid,
  input  logic [ADDR_W-1:0] viol_addr,
  input  logic              viol_write,
  input  logic              viol_data,
  input  logic              viol_atomic,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              reg_wen,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  logic             ctrl_wr, lock_wr;
  logic             en_q, pend_q, clr_q, lock_q;
  logic             clear_evt, capture_evt;
  logic [REG_W-1:0] status_q;
  logic             unused_wdata;

  assign ctrl_wr = reg_wen && (reg_sel == SEL_CTRL);
  assign lock_wr = reg_wen && (reg_sel == SEL_LOCK);
  assign unused_wdata = ^{reg_wdata[REG_W-1:3], reg_wdata[CTRL_PND_BIT]};

  pvc_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .viol        (viol_valid),
    .ctrl_wr     (ctrl_wr),
    .lock_wr     (lock_wr),
    .en_in       (reg_wdata[CTRL_EN_BIT]),
    .clr_in      (reg_wdata[CTRL_CLR_BIT]),
    .lock_in     (reg_wdata[0]),
    .en_q        (en_q),
    .pend_q      (pend_q),
    .clr_q       (clr_q),
    .lock_q      (lock_q),
    .clear_evt   (clear_evt),
    .capture_evt (capture_evt)
  );

  pvc_capture #(.ADDR_W(ADDR_W), .DATA_SIDE(DATA_SIDE)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (capture_evt),
    .addr      (viol_addr),
    .is_wr     (viol_write),
    .is_data   (viol_data),
    .is_atomic (viol_atomic),
    .status_q  (status_q)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_CTRL: begin
        reg_rdata[CTRL_EN_BIT]  = en_q;
        reg_rdata[CTRL_PND_BIT] = pend_q;
        reg_rdata[CTRL_CLR_BIT] = clr_q;
      end
      SEL_STATUS: reg_rdata = status_q;
      SEL_LOCK:   reg_rdata[0] = lock_q;
      default:    reg_rdata = '0;
    endcase
  end

  assign irq = pend_q & en_q;

  // R5
  first_fault_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clear_evt) |=> $stable(status_q));
  // R8
  race_keeps_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && clear_evt) |=> (pend_q && !$stable(clr_q) || pend_q));
endmodule

// File: tb/pviol_capture_tb.sv
module pviol_capture_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        viol_valid = 1'b0;
  logic [31:0] viol_addr = '0;
  logic        viol_write = 1'b0, viol_data = 1'b0, viol_atomic = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic        reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata_i, rdata_d;
  logic        irq_i, irq_d;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pviol_capture #(.ADDR_W(32), .DATA_SIDE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .viol_valid(viol_valid), .viol_addr(viol_addr),
    .viol_write(viol_write), .viol_data(viol_data), .viol_atomic(viol_atomic),
    .reg_sel(reg_sel), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_i), .irq(irq_i));

  pviol_capture #(.ADDR_W(32), .DATA_SIDE(1'b1)) u_dut_d (
    .clk(clk), .rst_n(rst_n), .viol_valid(viol_valid), .viol_addr(viol_addr),
    .viol_write(viol_write), .viol_data(viol_data), .viol_atomic(viol_atomic),
    .reg_sel(reg_sel), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_d), .irq(irq_d));

  // stimulus {addr, write, data, atomic} and expected status per layout
  localparam logic [31:0] V_ADDR  [5] = '{32'h4002_0004, 32'h3FFB_8000, 32'hFFFF_FFFF,
                                          32'h0000_0003, 32'h4006_FFFC};
  localparam logic [2:0]  V_FLAG  [5] = '{3'b000, 3'b111, 3'b010, 3'b101, 3'b100};
  localparam logic [31:0] V_EXP_I [5] = '{32'h0002_0004, 32'h003B_8003, 32'h003F_FFFE,
                                          32'h0000_0001, 32'h0006_FFFD};
  localparam logic [31:0] V_EXP_D [5] = '{32'h0020_0040, 32'h03B8_0030, 32'h03FF_FFC0,
                                          32'h0000_0030, 32'h006F_FFD0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_both(input logic [1:0] s, output logic [31:0] ri, output logic [31:0] rd);
    reg_sel = s;
    #1;
    ri = rdata_i;
    rd = rdata_d;
  endtask

  task automatic violate(input logic [31:0] a, input logic [2:0] f);
    @(negedge clk);
    viol_addr = a; {viol_write, viol_data, viol_atomic} = f; viol_valid = 1'b1;
    @(negedge clk);
    viol_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] ri, rd;
    do_reset();

    // R1 reset state
    rd_both(2'd0, ri, rd); chk("R1 ctrl_i", ri, 0); chk("R1 ctrl_d", rd, 0);
    rd_both(2'd1, ri, rd); chk("R1 stat_i", ri, 0); chk("R1 stat_d", rd, 0);
    rd_both(2'd2, ri, rd); chk("R1 lock_i", ri, 0); chk("R1 lock_d", rd, 0);
    chk("R1 irq", {30'd0, irq_i, irq_d}, 0);

    // R4 pending without enable, then enable raises irq
    violate(32'h4002_1000, 3'b100);
    rd_both(2'd0, ri, rd); chk("R4 pend_i", ri, 32'h2); chk("R4 pend_d", rd, 32'h2);
    chk("R4 irq masked", {30'd0, irq_i, irq_d}, 0);
    wr_reg(2'd0, 32'h1);
    rd_both(2'd0, ri, rd); chk("R4 ctrl_en", ri, 32'h3);
    chk("R4 irq on", {30'd0, irq_i, irq_d}, 32'h3);

    // R5 second fault does not overwrite
    violate(32'h4002_2000, 3'b011);
    rd_both(2'd1, ri, rd); chk("R5 stat_i", ri, 32'h0002_1001); chk("R5 stat_d", rd, 32'h0021_0010);

    // R6 / R7 clear and self-clearing bit
    wr_reg(2'd0, 32'h5);
    rd_both(2'd0, ri, rd); chk("R7 clr_read_1", ri, 32'h5); chk("R6 pend_gone", rd, 32'h5);
    chk("R6 irq off", {30'd0, irq_i, irq_d}, 0);
    @(negedge clk);
    rd_both(2'd0, ri, rd); chk("R7 clr_read_0", ri, 32'h1);

    // R11 pending bit not writable
    wr_reg(2'd0, 32'h3);
    rd_both(2'd0, ri, rd); chk("R11 pend_ro", ri, 32'h1);

    // R2 / R3 layout vectors
    for (int k = 0; k < 5; k++) begin
      violate(V_ADDR[k], V_FLAG[k]);
      rd_both(2'd1, ri, rd);
      chk("R2 layout_i", ri, V_EXP_I[k]);
      chk("R3 layout_d", rd, V_EXP_D[k]);
      chk("R4 irq_vec", {30'd0, irq_i, irq_d}, 32'h3);
      wr_reg(2'd0, 32'h5);
      rd_both(2'd0, ri, rd); chk("R6 cleared_vec", ri, 32'h5);
    end

    // R8 violation and clear in the same cycle
    violate(32'h4002_4000, 3'b000);
    @(negedge clk);
    viol_addr = 32'h4002_8004; {viol_write, viol_data, viol_atomic} = 3'b111; viol_valid = 1'b1;
    reg_sel = 2'd0; reg_wdata = 32'h5; reg_wen = 1'b1;
    @(negedge clk);
    viol_valid = 1'b0; reg_wen = 1'b0; reg_wdata = '0;
    rd_both(2'd0, ri, rd); chk("R8 pend_kept", ri, 32'h7);
    rd_both(2'd1, ri, rd); chk("R8 stat_i", ri, 32'h0002_8007); chk("R8 stat_d", rd, 32'h0028_0070);

    // R9 / R10 lock
    wr_reg(2'd2, 32'h1);
    rd_both(2'd2, ri, rd); chk("R9 lock_set", ri, 32'h1); chk("R9 lock_set_d", rd, 32'h1);
    wr_reg(2'd2, 32'h0);
    rd_both(2'd2, ri, rd); chk("R9 lock_hold", ri, 32'h1);
    wr_reg(2'd0, 32'h0);
    rd_both(2'd0, ri, rd); chk("R10 en_frozen", ri, 32'h3);
    chk("R10 irq_kept", {30'd0, irq_i, irq_d}, 32'h3);
    do_reset();
    rd_both(2'd2, ri, rd); chk("R9 lock_reset", ri, 32'h0);
    rd_both(2'd0, ri, rd); chk("R1 ctrl_after_reset", ri, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule